// File: doc/BRIEF.md
# Match-Gated Serial Secure Memory Controller

This block is the slave side of a three-wire serial key: a transfer strobe, a serial clock and one bidirectional data line. A fast system clock samples the three pins. The block decodes a 24-bit command word and then runs one of two kinds of transfer. A normal transfer first shifts out a 64-bit identification. It then takes in a 64-bit compare code. If that code equals a stored match code, which is never readable, the transfer gives read or write access to 384 bits of secure storage. A read with a wrong code returns pseudo-random bits, so the failure is not visible. A write with a wrong code is discarded.

A program transfer loads a new identification and match code, and clears all storage before it does so. Program transfers also reach an external expiry timer. Some hand it commands and a new day count. Others read back its day-clock and days-remaining values. While the timer reports expiry, every path that changes state is closed.

The data line is split into `dq_out` and `dq_oe`, so the pad driver sits outside the block.

Top module: `skey_ctrl`

## Requirements
- R1: After `rst_n` is released, `dq_oe` is 0, and the identification, match code and secure storage all read as zero.
- R2: The command word is taken least significant bit first. Its bits 7:0 are the function code, bits 9:8 the mode (01 normal, 10 program) and bits 23:20 must be 1011. The only accepted words are 0xB00162 (normal read), 0xB0019D (normal write), 0xB0029D (program write), 0xB002F1 (read day clock), 0xB002F2 (write days), 0xB002F3 (read days), 0xB002F4 (stop), 0xB002F5 (arm) and 0xB002F6 (lock). Any other word makes the block ignore the rest of the transfer: `dq_oe` stays 0 and no timer strobe is issued.
- R3: A normal transfer shifts out the 64 identification bits, bit 0 first. Each bit is driven with `dq_oe`=1 after a falling serial-clock edge, and `dq_oe` returns to 0 after the next rising edge.
- R4: After 64 compare bits are taken in (bit 0 first), a normal read with a matching code shifts out the 384 storage bits, bit 0 first.
- R5: A normal write with a matching code stores the 384 bits that follow, bit 0 first.
- R6: A normal read with a non-matching code still drives all 384 bit slots, with data taken from a free-running 16-bit maximal-length LFSR. This data is neither constant nor equal to the stored content.
- R7: A normal write with a non-matching code leaves the storage unchanged.
- R8: A program write clears the whole storage. It then takes 64 identification bits followed by 64 match-code bits, each bit 0 first.
- R9: Read day clock shifts out the 20-bit `tmr_dayclk` value, and read days shifts out the 9-bit `tmr_days` value, both bit 0 first. Each value is captured when the command word completes.
- R10: Write days takes 9 bits (bit 0 first) and then pulses `tmr_stb` for one cycle with `tmr_op`=0 and `tmr_wdays` set to the value. Stop, arm and lock pulse `tmr_stb` when their command word completes, with `tmr_op` = 1, 2 and 3 respectively.
- R11: While `expired` is 1, normal writes, program writes and write-days transfers change nothing and issue no strobe. Reads still work.
- R12: `pin_rst` low ends any transfer at once: `dq_oe` falls, and serial clocks are ignored until `pin_rst` rises again, which starts a fresh command word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_rst | input | 1 | Transfer strobe; high while a transfer is open |
| pin_clk | input | 1 | Serial clock from the host |
| dq_in | input | 1 | Serial data from the host |
| dq_out | output | 1 | Serial data to the host |
| dq_oe | output | 1 | Drive enable for the data pad |
| expired | input | 1 | Expiry flag from the timer; blocks all writes |
| tmr_dayclk | input | 20 | Day-clock count from the timer |
| tmr_days | input | 9 | Days-remaining count from the timer |
| tmr_stb | output | 1 | One-cycle strobe for a timer command |
| tmr_op | output | 2 | Timer command: 0 load days, 1 stop, 2 arm, 3 lock |
| tmr_wdays | output | 9 | New day count that goes with op 0 |

## Verification
The assertions rely on the serial pins changing far more slowly than the system clock. Rising and falling serial edges must then land several cycles apart, so a strobe can never be followed by another in the next cycle. A rise and a fall also never arrive in the same cycle. The stimulus holds each serial clock phase for six system cycles. It changes the data line only while the serial clock is low, and changes `pin_rst` only while the serial clock is steady, so every pin is stable across the two-flop synchronizer before it is used.

// File: rtl/skey_pkg.sv
package skey_pkg;

   localparam int CMD_W = 24;

   // Function codes (low byte of the command word)
   localparam logic [7:0] FN_RD    = 8'h62;
   localparam logic [7:0] FN_WR    = 8'h9D;
   localparam logic [7:0] FN_PWR   = 8'h9D;
   localparam logic [7:0] FN_RCLK  = 8'hF1;
   localparam logic [7:0] FN_WDAYS = 8'hF2;
   localparam logic [7:0] FN_RDAYS = 8'hF3;
   localparam logic [7:0] FN_STOP  = 8'hF4;
   localparam logic [7:0] FN_ARM   = 8'hF5;
   localparam logic [7:0] FN_LOCK  = 8'hF6;

   localparam logic [1:0] OP_WDAYS = 2'd0;
   localparam logic [1:0] OP_STOP  = 2'd1;
   localparam logic [1:0] OP_ARM   = 2'd2;
   localparam logic [1:0] OP_LOCK  = 2'd3;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_CMD,
      ST_ID_OUT,
      ST_CMP_IN,
      ST_SEC_RD,
      ST_SEC_WR,
      ST_PRG_WR,
      ST_VAL_RD,
      ST_DAYS_WR,
      ST_HALT
   } st_e;

endpackage

// File: rtl/skey_pin_sync.sv
module skey_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_rst,
   input  logic pin_clk,
   input  logic pin_dq,
   output logic rst_s,
   output logic dq_s,
   output logic clk_rise,
   output logic clk_fall
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("skey_pin_sync: STAGES must be at least 2");
      end
   endgenerate

   // stage index 0 is nearest the pins; element bits are {dq, clk, rst}
   logic [STAGES-1:0][2:0] stg;
   logic                   clk_prev;
   logic [2:0]             last;

   assign last = stg[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg      <= '0;
         clk_prev <= 1'b0;
      end else begin
         stg      <= {stg[STAGES-2:0], {pin_dq, pin_clk, pin_rst}};
         clk_prev <= last[1];
      end
   end

   assign rst_s    = last[0];
   assign dq_s     = last[2];
   assign clk_rise = last[1] & ~clk_prev;
   assign clk_fall = ~last[1] & clk_prev;

endmodule

// File: rtl/skey_lfsr.sv
module skey_lfsr #(
   parameter int          WIDTH = 16,
   parameter logic [15:0] TAPS  = 16'hB400,
   parameter logic [15:0] SEED  = 16'hACE1
) (
   input  logic clk,
   input  logic rst_n,
   output logic out_bit
);

   generate
      if (WIDTH != 16) begin : g_bad_width
         $error("skey_lfsr: only a 16-bit register is supported");
      end
      if (SEED == 16'h0000) begin : g_bad_seed
         $error("skey_lfsr: seed must be nonzero");
      end
      if (TAPS[15] != 1'b1) begin : g_bad_taps
         $error("skey_lfsr: top tap must be set");
      end
   endgenerate

   logic [15:0] sr_q;

   // Galois form, shifting right
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr_q <= SEED;
      else        sr_q <= (sr_q >> 1) ^ (sr_q[0] ? TAPS : 16'h0000);
   end

   assign out_bit = sr_q[0];

   // R6
   nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sr_q != 16'h0000);

endmodule

// File: rtl/skey_store.sv
module skey_store #(
   parameter int ID_W  = 64,
   parameter int MEM_W = 384,
   parameter int IDX_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             erase,
   input  logic             id_we,
   input  logic             key_we,
   input  logic             mem_we,
   input  logic [IDX_W-1:0] idx,
   input  logic             wbit,
   input  logic [ID_W-1:0]  cmp_vec,
   output logic             id_bit,
   output logic             mem_bit,
   output logic             key_eq
);

   localparam int IW = $clog2(ID_W);

   logic [ID_W-1:0]  id_q;
   logic [ID_W-1:0]  key_q;
   logic [MEM_W-1:0] mem_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         id_q  <= '0;
         key_q <= '0;
         mem_q <= '0;
      end else if (erase) begin
         id_q  <= '0;
         key_q <= '0;
         mem_q <= '0;
      end else begin
         if (id_we)  id_q[idx[IW-1:0]]  <= wbit;
         if (key_we) key_q[idx[IW-1:0]] <= wbit;
         if (mem_we) mem_q[idx]         <= wbit;
      end
   end

   assign id_bit  = id_q[idx[IW-1:0]];
   assign mem_bit = mem_q[idx];
   assign key_eq  = (key_q == cmp_vec);

   // R8
   one_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({erase, id_we, key_we, mem_we}));

endmodule

// File: rtl/skey_ctrl.sv
module skey_ctrl
   import skey_pkg::*;
#(
   parameter int          ID_W        = 64,
   parameter int          MEM_W       = 384,
   parameter int          DCLK_W      = 20,
   parameter int          DAYS_W      = 9,
   parameter int          SYNC_STAGES = 2,
   parameter logic [15:0] NORM_HDR    = 16'hB001,
   parameter logic [15:0] PROG_HDR    = 16'hB002,
   parameter logic [15:0] GARB_SEED   = 16'hACE1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pin_rst,
   input  logic              pin_clk,
   input  logic              dq_in,
   output logic              dq_out,
   output logic              dq_oe,
   input  logic              expired,
   input  logic [DCLK_W-1:0] tmr_dayclk,
   input  logic [DAYS_W-1:0] tmr_days,
   output logic              tmr_stb,
   output logic [1:0]        tmr_op,
   output logic [DAYS_W-1:0] tmr_wdays
);

   localparam int CNT_W = $clog2(MEM_W);

   generate
      if ((ID_W & (ID_W - 1)) != 0 || ID_W < 8) begin : g_bad_id
         $error("skey_ctrl: ID_W must be a power of two, at least 8");
      end
      if (MEM_W < 2 * ID_W || MEM_W < CMD_W || MEM_W <= DCLK_W) begin : g_bad_mem
         $error("skey_ctrl: MEM_W too small for the counter");
      end
      if (DCLK_W < DAYS_W || DAYS_W < 2) begin : g_bad_tmr
         $error("skey_ctrl: timer widths inconsistent");
      end
      if (NORM_HDR[1:0] != 2'b01 || PROG_HDR[1:0] != 2'b10 ||
          NORM_HDR[15:12] != 4'hB || PROG_HDR[15:12] != 4'hB) begin : g_bad_hdr
         $error("skey_ctrl: header mode bits or trailer malformed");
      end
   endgenerate

   logic rst_s, dq_s, clk_rise, clk_fall;
   logic garb_bit, id_bit, mem_bit, key_eq;
   logic erase, id_we, key_we, mem_we;

   st_e                st;
   logic [CNT_W-1:0]   cnt;
   logic [CNT_W-1:0]   rd_last;
   logic [CMD_W-2:0]   cmd_sh;
   logic [CMD_W-1:0]   cmd_nx;
   logic [ID_W-1:0]    cmp_sh;
   logic [DCLK_W-1:0]  rd_sh;
   logic [DAYS_W-2:0]  days_sh;
   logic [DAYS_W-1:0]  days_nx;
   logic               rd_mode;
   logic               oe_q, dq_q;
   logic [7:0]         fn;
   logic               norm_ok, prog_ok, cmd_done;

   skey_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .pin_rst(pin_rst), .pin_clk(pin_clk), .pin_dq(dq_in),
      .rst_s(rst_s), .dq_s(dq_s), .clk_rise(clk_rise), .clk_fall(clk_fall)
   );

   skey_lfsr #(.SEED(GARB_SEED)) u_garb (
      .clk(clk), .rst_n(rst_n), .out_bit(garb_bit)
   );

   skey_store #(.ID_W(ID_W), .MEM_W(MEM_W), .IDX_W(CNT_W)) u_store (
      .clk(clk), .rst_n(rst_n),
      .erase(erase), .id_we(id_we), .key_we(key_we), .mem_we(mem_we),
      .idx(cnt), .wbit(dq_s), .cmp_vec(cmp_sh),
      .id_bit(id_bit), .mem_bit(mem_bit), .key_eq(key_eq)
   );

   assign cmd_nx   = {dq_s, cmd_sh};
   assign days_nx  = {dq_s, days_sh};
   assign fn       = cmd_nx[7:0];
   assign norm_ok  = (cmd_nx[CMD_W-1:8] == NORM_HDR);
   assign prog_ok  = (cmd_nx[CMD_W-1:8] == PROG_HDR);
   assign cmd_done = rst_s && (st == ST_CMD) && clk_rise && (cnt == CNT_W'(CMD_W - 1));

   assign erase  = cmd_done && prog_ok && (fn == FN_PWR) && !expired;
   assign id_we  = rst_s && (st == ST_PRG_WR) && clk_rise && (cnt <  CNT_W'(ID_W));
   assign key_we = rst_s && (st == ST_PRG_WR) && clk_rise && (cnt >= CNT_W'(ID_W));
   assign mem_we = rst_s && (st == ST_SEC_WR) && clk_rise && key_eq && !expired;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         cnt       <= '0;
         rd_last   <= '0;
         cmd_sh    <= '0;
         cmp_sh    <= '0;
         rd_sh     <= '0;
         days_sh   <= '0;
         rd_mode   <= 1'b0;
         oe_q      <= 1'b0;
         dq_q      <= 1'b0;
         tmr_stb   <= 1'b0;
         tmr_op    <= OP_WDAYS;
         tmr_wdays <= '0;
      end else begin
         tmr_stb <= 1'b0;
         if (!rst_s) begin
            st   <= ST_IDLE;
            cnt  <= '0;
            oe_q <= 1'b0;
         end else begin
            case (st)
               ST_IDLE: begin
                  st  <= ST_CMD;
                  cnt <= '0;
               end
               ST_CMD: if (clk_rise) begin
                  cmd_sh <= cmd_nx[CMD_W-1:1];
                  cnt    <= cnt + 1'b1;
                  if (cmd_done) begin
                     cnt <= '0;
                     st  <= ST_HALT;
                     if (norm_ok && (fn == FN_RD || fn == FN_WR)) begin
                        st      <= ST_ID_OUT;
                        rd_mode <= (fn == FN_RD);
                     end else if (prog_ok) begin
                        case (fn)
                           FN_PWR:   if (!expired) st <= ST_PRG_WR;
                           FN_RCLK: begin
                              st      <= ST_VAL_RD;
                              rd_sh   <= tmr_dayclk;
                              rd_last <= CNT_W'(DCLK_W - 1);
                           end
                           FN_RDAYS: begin
                              st      <= ST_VAL_RD;
                              rd_sh   <= DCLK_W'(tmr_days);
                              rd_last <= CNT_W'(DAYS_W - 1);
                           end
                           FN_WDAYS: st <= ST_DAYS_WR;
                           FN_STOP:  begin tmr_stb <= 1'b1; tmr_op <= OP_STOP; end
                           FN_ARM:   begin tmr_stb <= 1'b1; tmr_op <= OP_ARM;  end
                           FN_LOCK:  begin tmr_stb <= 1'b1; tmr_op <= OP_LOCK; end
                           default:  ;
                        endcase
                     end
                  end
               end
               ST_ID_OUT: begin
                  if (clk_fall) begin
                     oe_q <= 1'b1;
                     dq_q <= id_bit;
                  end else if (clk_rise) begin
                     oe_q <= 1'b0;
                     cnt  <= cnt + 1'b1;
                     if (cnt == CNT_W'(ID_W - 1)) begin
                        cnt <= '0;
                        st  <= ST_CMP_IN;
                     end
                  end
               end
               ST_CMP_IN: if (clk_rise) begin
                  cmp_sh <= {dq_s, cmp_sh[ID_W-1:1]};
                  cnt    <= cnt + 1'b1;
                  if (cnt == CNT_W'(ID_W - 1)) begin
                     cnt <= '0;
                     st  <= rd_mode ? ST_SEC_RD : ST_SEC_WR;
                  end
               end
               ST_SEC_RD: begin
                  if (clk_fall) begin
                     oe_q <= 1'b1;
                     dq_q <= key_eq ? mem_bit : garb_bit;
                  end else if (clk_rise) begin
                     oe_q <= 1'b0;
                     cnt  <= cnt + 1'b1;
                     if (cnt == CNT_W'(MEM_W - 1)) st <= ST_HALT;
                  end
               end
               ST_SEC_WR: begin
                  if (!key_eq || expired) st <= ST_HALT;
                  else if (clk_rise) begin
                     cnt <= cnt + 1'b1;
                     if (cnt == CNT_W'(MEM_W - 1)) st <= ST_HALT;
                  end
               end
               ST_PRG_WR: if (clk_rise) begin
                  cnt <= cnt + 1'b1;
                  if (cnt == CNT_W'(2 * ID_W - 1)) st <= ST_HALT;
               end
               ST_VAL_RD: begin
                  if (clk_fall) begin
                     oe_q <= 1'b1;
                     dq_q <= rd_sh[0];
                  end else if (clk_rise) begin
                     oe_q  <= 1'b0;
                     rd_sh <= rd_sh >> 1;
                     cnt   <= cnt + 1'b1;
                     if (cnt == rd_last) st <= ST_HALT;
                  end
               end
               ST_DAYS_WR: if (clk_rise) begin
                  days_sh <= days_nx[DAYS_W-1:1];
                  cnt     <= cnt + 1'b1;
                  if (cnt == CNT_W'(DAYS_W - 1)) begin
                     st <= ST_HALT;
                     if (!expired) begin
                        tmr_stb   <= 1'b1;
                        tmr_op    <= OP_WDAYS;
                        tmr_wdays <= days_nx;
                     end
                  end
               end
               ST_HALT: ;
               default: st <= ST_IDLE;
            endcase
         end
      end
   end

   assign dq_out = dq_q;
   assign dq_oe  = oe_q;

   // R12
   rst_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rst_s |=> !dq_oe);

   // R3
   out_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clk_rise |=> !dq_oe);

   // R10
   stb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_stb |=> !tmr_stb);

   // R11
   wdays_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_stb && tmr_op == OP_WDAYS) |-> !$past(expired));

endmodule

// File: tb/skey_ctrl_tb.sv
module skey_ctrl_tb;

   localparam int HALF = 6;
   localparam logic [23:0] W_NR = 24'hB00162, W_NW = 24'hB0019D, W_PW = 24'hB0029D;
   localparam logic [23:0] W_RC = 24'hB002F1, W_WD = 24'hB002F2, W_RD = 24'hB002F3;
   localparam logic [23:0] W_SP = 24'hB002F4, W_AR = 24'hB002F5, W_LK = 24'hB002F6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic        pin_rst = 1'b0, pin_clk = 1'b0, pin_dq = 1'b0, expired = 1'b0;
   logic [19:0] tmr_dayclk = '0;
   logic [8:0]  tmr_days = '0;
   logic        dq_out, dq_oe, tmr_stb;
   logic [1:0]  tmr_op;
   logic [8:0]  tmr_wdays;

   skey_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .pin_rst(pin_rst), .pin_clk(pin_clk), .dq_in(pin_dq),
      .dq_out(dq_out), .dq_oe(dq_oe), .expired(expired),
      .tmr_dayclk(tmr_dayclk), .tmr_days(tmr_days),
      .tmr_stb(tmr_stb), .tmr_op(tmr_op), .tmr_wdays(tmr_wdays)
   );

   int checks = 0, errors = 0;
   int stb_n = 0;
   logic [1:0] last_op = '0;
   logic [8:0] last_wd = '0;
   int rst_low_age = 0;
   int oe_viol = 0;

   // reference model of stored state
   logic [63:0]  m_id = '0, m_key = '0;
   logic [383:0] m_mem = '0;

   // per-clock monitor: strobe capture and high-Z while the strobe pin is low
   always @(negedge clk) begin
      if (tmr_stb) begin
         stb_n++;
         last_op = tmr_op;
         last_wd = tmr_wdays;
      end
      if (pin_rst) rst_low_age = 0;
      else if (rst_low_age < 100) rst_low_age++;
      if (rst_n && rst_low_age >= 5 && dq_oe) oe_viol++;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [383:0] act, input logic [383:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic wait_half();
      repeat (HALF) @(negedge clk);
   endtask

   task automatic bit_in(input logic b);
      pin_clk = 1'b0; pin_dq = b; wait_half();
      pin_clk = 1'b1; wait_half();
   endtask

   task automatic bit_out(output logic b, inout bit bad);
      pin_clk = 1'b0; wait_half();
      b = dq_out;
      if (!dq_oe) bad = 1'b1;
      pin_clk = 1'b1; wait_half();
      if (dq_oe) bad = 1'b1;
   endtask

   task automatic open_x();
      pin_rst = 1'b1; wait_half();
   endtask

   task automatic close_x();
      pin_rst = 1'b0; wait_half();
      pin_clk = 1'b0; wait_half();
   endtask

   task automatic send_cmd(input logic [23:0] w);
      for (int i = 0; i < 24; i++) bit_in(w[i]);
   endtask

   task automatic norm_xfer(input bit wr, input logic [63:0] key, input logic [383:0] wdata,
                            output logic [63:0] idg, output logic [383:0] dg, output bit bad);
      logic b;
      bad = 1'b0; idg = '0; dg = '0;
      open_x();
      send_cmd(wr ? W_NW : W_NR);
      for (int i = 0; i < 64; i++) begin bit_out(b, bad); idg[i] = b; end
      for (int i = 0; i < 64; i++) bit_in(key[i]);
      for (int i = 0; i < 384; i++) begin
         if (wr) bit_in(wdata[i]);
         else begin bit_out(b, bad); dg[i] = b; end
      end
      close_x();
   endtask

   task automatic prog_xfer(input logic [63:0] id, input logic [63:0] key);
      open_x();
      send_cmd(W_PW);
      for (int i = 0; i < 64; i++) bit_in(id[i]);
      for (int i = 0; i < 64; i++) bit_in(key[i]);
      close_x();
   endtask

   task automatic val_rd(input logic [23:0] w, input int n, output logic [19:0] v, output bit bad);
      logic b;
      bad = 1'b0; v = '0;
      open_x();
      send_cmd(w);
      for (int i = 0; i < n; i++) begin bit_out(b, bad); v[i] = b; end
      close_x();
   endtask

   task automatic days_wr(input logic [8:0] d);
      open_x();
      send_cmd(W_WD);
      for (int i = 0; i < 9; i++) bit_in(d[i]);
      close_x();
   endtask

   task automatic cmd_only(input logic [23:0] w);
      open_x(); send_cmd(w); close_x();
   endtask

   // a rejected command followed by clock cycles; counts samples with the pad driven
   task automatic bad_cmd(input logic [23:0] w, output int hi);
      hi = 0;
      open_x();
      send_cmd(w);
      for (int i = 0; i < 64; i++) begin
         pin_clk = 1'b0; pin_dq = i[0]; wait_half();
         if (dq_oe) hi++;
         pin_clk = 1'b1; wait_half();
         if (dq_oe) hi++;
      end
      close_x();
   endtask

   function automatic logic [383:0] pat(input int seed);
      logic [383:0] p;
      for (int i = 0; i < 384; i++) p[i] = (((i * 7 + seed) % 5) == 1) ^ ((i >> 3) & 1);
      return p;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [63:0]  idg;
      logic [383:0] dg;
      logic [19:0]  v;
      bit           bad;
      int           hi;
      int           s0;
      logic [63:0]  id_a  = 64'h0123_4567_89AB_CDEF;
      logic [63:0]  key_a = 64'hF00D_CAFE_1234_8765;
      logic [383:0] p1 = pat(0), p2 = pat(3), p3 = pat(1);

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R1: reset state
      chk(dq_oe == 1'b0, "R1", "dq_oe after reset", 384'(dq_oe), 384'(0));
      norm_xfer(1'b0, m_key, '0, idg, dg, bad);
      chk(idg == m_id && !bad, "R1", "id after reset", 384'(idg), 384'(m_id));
      chk(dg == m_mem, "R1", "storage after reset", dg, m_mem);

      // R8: program id and key
      prog_xfer(id_a, key_a);
      m_id = id_a; m_key = key_a; m_mem = '0;

      // R5: matching write
      norm_xfer(1'b1, key_a, p1, idg, dg, bad);
      m_mem = p1;
      chk(idg == m_id && !bad, "R3", "id shifted out lsb first", 384'(idg), 384'(m_id));

      // R4: matching read
      norm_xfer(1'b0, key_a, '0, idg, dg, bad);
      chk(idg == m_id, "R8", "programmed id", 384'(idg), 384'(m_id));
      chk(dg == m_mem && !bad, "R5", "matching write then read", dg, m_mem);

      // R6: wrong key read gives garbled data
      norm_xfer(1'b0, key_a ^ 64'h1, '0, idg, dg, bad);
      chk(!bad, "R6", "garbled slots driven", 384'(bad), 384'(0));
      chk(dg != m_mem && dg != '0 && dg != '1, "R6", "garbled data", dg, ~m_mem);

      // R7: wrong key write is ignored
      norm_xfer(1'b1, key_a ^ 64'h8000_0000_0000_0000, p2, idg, dg, bad);
      norm_xfer(1'b0, key_a, '0, idg, dg, bad);
      chk(dg == m_mem, "R7", "storage after mismatched write", dg, m_mem);

      // R2: rejected command words
      s0 = stb_n;
      bad_cmd(24'hB00163, hi);
      chk(hi == 0, "R2", "bad function code", 384'(hi), 384'(0));
      bad_cmd(24'hB00362, hi);
      chk(hi == 0, "R2", "bad mode bits 11", 384'(hi), 384'(0));
      bad_cmd(24'hA00162, hi);
      chk(hi == 0, "R2", "bad trailer", 384'(hi), 384'(0));
      bad_cmd(24'hB001F4, hi);
      chk(hi == 0 && stb_n == s0, "R2", "timer code in normal mode", 384'(stb_n - s0), 384'(0));

      // R9: timer reads
      tmr_dayclk = 20'hA5C3E; tmr_days = 9'h1B3;
      val_rd(W_RC, 20, v, bad);
      chk(v == 20'hA5C3E && !bad, "R9", "day clock read", 384'(v), 384'h A5C3E);
      val_rd(W_RD, 9, v, bad);
      chk(v == 20'h001B3 && !bad, "R9", "days read", 384'(v), 384'h1B3);

      // R10: timer commands
      s0 = stb_n;
      days_wr(9'h12D);
      chk(stb_n == s0 + 1 && last_op == 2'd0 && last_wd == 9'h12D, "R10", "write days",
          384'(last_wd), 384'h12D);
      cmd_only(W_SP);
      chk(stb_n == s0 + 2 && last_op == 2'd1, "R10", "stop op", 384'(last_op), 384'd1);
      cmd_only(W_AR);
      chk(stb_n == s0 + 3 && last_op == 2'd2, "R10", "arm op", 384'(last_op), 384'd2);
      cmd_only(W_LK);
      chk(stb_n == s0 + 4 && last_op == 2'd3, "R10", "lock op", 384'(last_op), 384'd3);

      // R11: expiry blocks writes
      expired = 1'b1;
      s0 = stb_n;
      days_wr(9'h055);
      chk(stb_n == s0, "R11", "write days while expired", 384'(stb_n - s0), 384'(0));
      norm_xfer(1'b1, key_a, p3, idg, dg, bad);
      prog_xfer(64'hDEAD_BEEF_0000_1111, 64'h1);
      norm_xfer(1'b0, key_a, '0, idg, dg, bad);
      chk(idg == m_id, "R11", "id after blocked program write", 384'(idg), 384'(m_id));
      chk(dg == m_mem, "R11", "storage after blocked write", dg, m_mem);
      expired = 1'b0;

      // R12: abort mid transfer
      open_x();
      send_cmd(W_NR);
      for (int i = 0; i < 10; i++) bit_out(v[0], bad);
      pin_clk = 1'b0; wait_half();
      hi = int'(dq_oe);
      pin_rst = 1'b0; wait_half();
      chk(hi == 1 && dq_oe == 1'b0, "R12", "pad released on abort", 384'(dq_oe), 384'(0));
      hi = 0;
      for (int i = 0; i < 6; i++) begin
         pin_clk = 1'b1; wait_half(); if (dq_oe) hi++;
         pin_clk = 1'b0; wait_half(); if (dq_oe) hi++;
      end
      chk(hi == 0, "R12", "clocks ignored while strobe low", 384'(hi), 384'(0));
      norm_xfer(1'b0, key_a, '0, idg, dg, bad);
      chk(idg == m_id && dg == m_mem && !bad, "R12", "fresh transfer after abort", 384'(idg), 384'(m_id));

      // R8: program write erases storage
      prog_xfer(64'h5A5A_0F0F_3C3C_9999, 64'h0BAD_F00D_0000_0001);
      m_id = 64'h5A5A_0F0F_3C3C_9999; m_key = 64'h0BAD_F00D_0000_0001; m_mem = '0;
      norm_xfer(1'b0, m_key, '0, idg, dg, bad);
      chk(idg == m_id, "R8", "new id", 384'(idg), 384'(m_id));
      chk(dg == m_mem, "R8", "storage erased", dg, m_mem);

      chk(oe_viol == 0, "R12", "pad driven while strobe low", 384'(oe_viol), 384'(0));

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule